// File: doc/BRIEF.md
# Dual-Channel Complex Sample Serial Formatter

This block takes one complex baseband sample from each of two receiver channels (an in-phase word and a quadrature word per channel, all captured together on a single valid strobe). It shifts them out on one serial data line per channel. Both lines share a generated bit clock, a frame-sync output and a ready output, so a downstream serial port sees both channels framed in lockstep. Each transfer carries the in-phase word and then the quadrature word, each sent most significant bit first in two's complement.

Static configuration inputs set the framing and the sense of the strobes. In per-word framing, frame sync marks the first bit of each word. In paired framing, it marks only the first bit of the I/Q pair. The bit clock, frame sync and ready can each be inverted on their own. A one-entry holding buffer takes a sample that arrives while a transfer is running, and that sample goes out directly after the current one with no idle bit. If a sample arrives while the buffer is still occupied, it is discarded and a sticky overflow flag is raised. Between transfers the data lines rest at 0.

Top module: `iq_serial_fmt`

## Requirements
- R1: Each transfer is 2*W bits long on both data lines at once. The first W bits are the channel's I word and the last W bits are its Q word, each sent MSB first (bit k of the transfer is bit 2W-1-k of {I,Q}).
- R2: With `cfg_packed`=0, frame sync is active during bit 0 and bit W of a transfer and inactive on every other bit.
- R3: With `cfg_packed`=1, frame sync is active during bit 0 only.
- R4: Frame sync is active-high when `cfg_sfs_pol`=0 and active-low when `cfg_sfs_pol`=1.
- R5: Every bit lasts 2*DIV clock cycles. With `cfg_sck_pol`=0, `ser_clk` is 1 in the first half of every bit and 0 in the second half, so data changes on its rising edge. With `cfg_sck_pol`=1 both levels are inverted, so data changes on the falling edge.
- R6: Ready is active for every bit of a transfer, and it first becomes active in the same cycle as bit 0. It is active-high when `cfg_rdy_pol`=0 and active-low when `cfg_rdy_pol`=1.
- R7: When no transfer is running, both data lines are 0 and frame sync and ready are inactive.
- R8: A sample accepted while a transfer is running is sent starting on the bit right after the last bit of that transfer.
- R9: A valid strobe that arrives while the holding buffer is full and is not being emptied in that cycle sets `ovf`. `ovf` then stays set until reset, and that sample is never sent. `ovf` stays 0 when no such collision occurs.
- R10: After reset both data lines are 0, frame sync and ready are inactive and `ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_packed | input | 1 | 1: one frame sync per I/Q pair; 0: one frame sync per word |
| cfg_sck_pol | input | 1 | Bit clock inversion |
| cfg_sfs_pol | input | 1 | 1: frame sync active-low |
| cfg_rdy_pol | input | 1 | 1: ready active-low |
| smp_valid | input | 1 | Capture strobe for the four sample words |
| a_i | input | W | Channel A in-phase word |
| a_q | input | W | Channel A quadrature word |
| b_i | input | W | Channel B in-phase word |
| b_q | input | W | Channel B quadrature word |
| ser_a | output | 1 | Channel A serial data |
| ser_b | output | 1 | Channel B serial data |
| ser_clk | output | 1 | Shared bit clock |
| ser_fs | output | 1 | Shared frame sync |
| ser_rdy | output | 1 | Shared ready |
| ovf | output | 1 | Sticky holding-buffer overflow |

## Verification
The hardest state to reach from the ports is a full holding buffer that meets a new strobe in the middle of a transfer. The same sequence must also show that the buffered sample follows with no gap and that the colliding sample never appears. The bench reaches this state by running the frame capture and the strobe driver in parallel. It waits for ready to mark the start of one transfer, then issues two more samples a few bits in. The capture side then checks two consecutive transfers bit by bit, followed by a stretch of idle line.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;
  localparam int NCH = 2;

  typedef struct packed {
    logic packed_mode;
    logic sck_inv;
    logic sfs_inv;
    logic rdy_inv;
  } fmt_cfg_t;
endpackage

// File: rtl/sfmt_bitclk.sv
module sfmt_bitclk #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic half_o,
  output logic bit_start_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          half_q, half_d;
  logic          adv;

  always_comb begin
    adv    = (cnt_q == CNT_TOP);
    cnt_d  = adv ? '0 : CW'(cnt_q + 1'b1);
    half_d = ~half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (adv) half_q <= half_d;
    end
  end

  assign half_o      = half_q;
  assign bit_start_o = adv & half_q;

  // R5
  half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(half_q));
  // R5
  bit_first_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start_o |=> !half_q);
endmodule

// File: rtl/sfmt_holdbuf.sv
module sfmt_holdbuf #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          take_i,
  output logic          full_o,
  output logic [DW-1:0] data_o,
  output logic          ovf_o
);
  logic          full_q, full_d;
  logic [DW-1:0] data_q;
  logic          ovf_q, ovf_d;
  logic          wr_en;
  logic          collide;

  always_comb begin
    wr_en   = in_valid & (~full_q | take_i);
    collide = in_valid & full_q & ~take_i;
    full_d  = full_q;
    if (wr_en)       full_d = 1'b1;
    else if (take_i) full_d = 1'b0;
    ovf_d = ovf_q | collide;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q <= in_data;
  end

  assign full_o = full_q;
  assign data_o = data_q;
  assign ovf_o  = ovf_q;

  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(in_valid && full_q && !take_i));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  // R8
  take_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> full_q);
endmodule

// File: rtl/sfmt_framer.sv
module sfmt_framer #(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_start_i,
  input  logic pend_full_i,
  input  logic packed_i,
  output logic load_o,
  output logic shift_o,
  output logic busy_o,
  output logic sync_act_o
);
  localparam int NB = 2 * W;
  localparam int IW = $clog2(NB);
  localparam logic [IW-1:0] LAST = IW'(NB - 1);
  localparam logic [IW-1:0] MID  = IW'(W);

  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          pk_q, pk_d;
  logic          at_last;

  always_comb begin
    at_last = (idx_q == LAST);
    load_o  = bit_start_i & (~busy_q | at_last) & pend_full_i;
    shift_o = bit_start_i & busy_q & ~at_last;
    busy_d  = busy_q;
    idx_d   = idx_q;
    pk_d    = pk_q;
    if (load_o) begin
      busy_d = 1'b1;
      idx_d  = '0;
      pk_d   = packed_i;
    end else if (shift_o) begin
      idx_d = IW'(idx_q + 1'b1);
    end else if (bit_start_i) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      pk_q   <= 1'b0;
    end else if (bit_start_i) begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      pk_q   <= pk_d;
    end
  end

  assign busy_o     = busy_q;
  assign sync_act_o = busy_q & ((idx_q == '0) | (~pk_q & (idx_q == MID)));

  // R8
  chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_start_i && busy_q && at_last && pend_full_i) |=> (busy_q && idx_q == '0));
  // R6
  start_from_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(pend_full_i));
  // R1
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_start_i |=> $stable(idx_q));
endmodule

// File: rtl/sfmt_chan.sv
module sfmt_chan #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           load_i,
  input  logic           shift_i,
  input  logic [2*W-1:0] word_i,
  output logic           msb_o
);
  logic [2*W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load_i)       sr_d = word_i;
    else if (shift_i) sr_d = {sr_q[2*W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (load_i | shift_i) sr_q <= sr_d;
  end

  assign msb_o = sr_q[2*W-1];
endmodule

// File: rtl/iq_serial_fmt.sv
module iq_serial_fmt
  import sfmt_pkg::*;
#(
  parameter int W   = 16,
  parameter int DIV = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_packed,
  input  logic         cfg_sck_pol,
  input  logic         cfg_sfs_pol,
  input  logic         cfg_rdy_pol,
  input  logic         smp_valid,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] a_q,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] b_q,
  output logic         ser_a,
  output logic         ser_b,
  output logic         ser_clk,
  output logic         ser_fs,
  output logic         ser_rdy,
  output logic         ovf
);
  localparam int FW = 2 * W;
  localparam int DW = NCH * FW;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fmt_cfg_t cfg;
  assign cfg = '{packed_mode: cfg_packed, sck_inv: cfg_sck_pol,
                 sfs_inv: cfg_sfs_pol, rdy_inv: cfg_rdy_pol};

  logic          half, bit_start;
  logic          pend_full, load, shift, busy, sync_act;
  logic [DW-1:0] in_word, held_word;
  logic [NCH-1:0] msb;
  logic [NCH-1:0] ser_bits;

  assign in_word = {b_i, b_q, a_i, a_q};

  sfmt_bitclk #(.DIV(DIV)) u_clk (
    .clk(clk), .rst_n(rst_int_n), .half_o(half), .bit_start_o(bit_start)
  );

  sfmt_holdbuf #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_int_n), .in_valid(smp_valid), .in_data(in_word),
    .take_i(load), .full_o(pend_full), .data_o(held_word), .ovf_o(ovf)
  );

  sfmt_framer #(.W(W)) u_frm (
    .clk(clk), .rst_n(rst_int_n), .bit_start_i(bit_start),
    .pend_full_i(pend_full), .packed_i(cfg.packed_mode), .load_o(load),
    .shift_o(shift), .busy_o(busy), .sync_act_o(sync_act)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sfmt_chan #(.W(W)) u_ch (
      .clk(clk), .load_i(load), .shift_i(shift),
      .word_i(held_word[c*FW +: FW]), .msb_o(msb[c])
    );
    assign ser_bits[c] = busy & msb[c];
  end

  assign ser_a   = ser_bits[0];
  assign ser_b   = ser_bits[1];
  assign ser_clk = ~(half ^ cfg.sck_inv);
  assign ser_fs  = sync_act ^ cfg.sfs_inv;
  assign ser_rdy = busy ^ cfg.rdy_inv;

  // R7
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> (!ser_a && !ser_b));
  // R2
  sync_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    sync_act |-> busy);
  // R6
  rdy_lead_sync_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy) |-> sync_act);
endmodule

// File: tb/sim_iq_serial_fmt.sv
module sim_iq_serial_fmt;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_packed, cfg_sck_pol, cfg_sfs_pol, cfg_rdy_pol;
  logic smp_valid;
  logic [W-1:0] a_i, a_q, b_i, b_q;
  logic ser_a, ser_b, ser_clk, ser_fs, ser_rdy, ovf;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  iq_serial_fmt #(.W(W), .DIV(1)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_packed(cfg_packed), .cfg_sck_pol(cfg_sck_pol),
    .cfg_sfs_pol(cfg_sfs_pol), .cfg_rdy_pol(cfg_rdy_pol), .smp_valid(smp_valid),
    .a_i(a_i), .a_q(a_q), .b_i(b_i), .b_q(b_q), .ser_a(ser_a), .ser_b(ser_b),
    .ser_clk(ser_clk), .ser_fs(ser_fs), .ser_rdy(ser_rdy), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic rdy_act();
    return ser_rdy ^ cfg_rdy_pol;
  endfunction

  function automatic logic fs_act();
    return ser_fs ^ cfg_sfs_pol;
  endfunction

  task automatic send(input logic [W-1:0] ai, aq, bi, bq);
    @(negedge clk);
    a_i = ai; a_q = aq; b_i = bi; b_q = bq;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic wait_rdy();
    int n = 0;
    while (!rdy_act() && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(rdy_act(), "R6 ready never became active", rdy_act(), 1);
  endtask

  // Called at the first cycle of bit 0; returns at the cycle after the last bit.
  task automatic capture(input logic [2*W-1:0] ea, eb, input bit pk, input string tag);
    logic [2*W-1:0] ga = '0, gb = '0, gfs = '0, efs = '0;
    bit clk_ok = 1'b1, rdy_ok = 1'b1;
    for (int k = 0; k < 2*W; k++) begin
      ga[2*W-1-k]  = ser_a;
      gb[2*W-1-k]  = ser_b;
      gfs[2*W-1-k] = fs_act();
      efs[2*W-1-k] = (k == 0) || (!pk && k == W);
      if (ser_clk !== ~cfg_sck_pol) clk_ok = 1'b0;
      if (!rdy_act()) rdy_ok = 1'b0;
      @(negedge clk);
      if (ser_clk !== cfg_sck_pol) clk_ok = 1'b0;
      if (!rdy_act()) rdy_ok = 1'b0;
      @(negedge clk);
    end
    chk(ga == ea, {"R1 channel A data ", tag}, ga, ea);
    chk(gb == eb, {"R1 channel B data ", tag}, gb, eb);
    chk(gfs == efs, pk ? {"R3 R4 sync pattern ", tag} : {"R2 R4 sync pattern ", tag}, gfs, efs);
    chk(clk_ok, {"R5 bit clock levels ", tag}, clk_ok, 1);
    chk(rdy_ok, {"R6 ready held through transfer ", tag}, rdy_ok, 1);
  endtask

  task automatic check_idle(input int cycles, input string tag);
    bit ok = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      if (ser_a || ser_b || fs_act() || rdy_act()) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, {"R7 idle lines ", tag}, ok, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ser_a == 0 && ser_b == 0, "R10 data after reset", {ser_a, ser_b}, 0);
    chk(!fs_act(), "R10 sync inactive after reset", ser_fs, cfg_sfs_pol);
    chk(!rdy_act(), "R10 ready inactive after reset", ser_rdy, cfg_rdy_pol);
    chk(ovf == 0, "R10 ovf after reset", ovf, 0);
  endtask

  task automatic t_unpacked();
    cfg_packed = 0; cfg_sck_pol = 0; cfg_sfs_pol = 0; cfg_rdy_pol = 0;
    send(16'h8001, 16'h7FFE, 16'hA5C3, 16'h0F0F);
    wait_rdy();
    capture({16'h8001, 16'h7FFE}, {16'hA5C3, 16'h0F0F}, 1'b0, "unpacked");
    check_idle(8, "after unpacked");
    chk(ovf == 0, "R9 no overflow on single sample", ovf, 0);
  endtask

  task automatic t_packed_inverted();
    cfg_packed = 1; cfg_sck_pol = 1; cfg_sfs_pol = 1; cfg_rdy_pol = 1;
    repeat (4) @(negedge clk);
    chk(ser_rdy == 1'b1 && ser_fs == 1'b1, "R4 R6 inverted idle levels", {ser_rdy, ser_fs}, 2'b11);
    send(16'h1234, 16'hFEDC, 16'hFFFF, 16'h0000);
    wait_rdy();
    capture({16'h1234, 16'hFEDC}, {16'hFFFF, 16'h0000}, 1'b1, "packed inverted");
    check_idle(6, "after packed");
  endtask

  task automatic t_chain_overflow();
    cfg_packed = 0; cfg_sck_pol = 0; cfg_sfs_pol = 0; cfg_rdy_pol = 1;
    repeat (4) @(negedge clk);
    send(16'h00FF, 16'hFF00, 16'h3C3C, 16'hC3C3);
    wait_rdy();
    fork
      begin
        capture({16'h00FF, 16'hFF00}, {16'h3C3C, 16'hC3C3}, 1'b0, "R8 first");
        capture({16'h5555, 16'hAAAA}, {16'h1357, 16'h9BDF}, 1'b0, "R8 chained");
        check_idle(80, "R9 dropped sample never sent");
      end
      begin
        repeat (6) @(negedge clk);
        send(16'h5555, 16'hAAAA, 16'h1357, 16'h9BDF);
        chk(ovf == 0, "R9 buffered sample raises no overflow", ovf, 0);
        send(16'hDEAD, 16'hBEEF, 16'hCAFE, 16'hF00D);
        chk(ovf == 1, "R9 overflow on full buffer", ovf, 1);
      end
    join
    chk(ovf == 1, "R9 overflow sticky", ovf, 1);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    smp_valid = 1'b0;
    a_i = '0; a_q = '0; b_i = '0; b_q = '0;
    cfg_packed = 0; cfg_sck_pol = 0; cfg_sfs_pol = 0; cfg_rdy_pol = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_unpacked();
    t_packed_inverted();
    t_chain_overflow();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule